// File: doc/BRIEF.md
# LED PWM Generator with Shadowed Prescaler

This block drives one active-high LED pin from four small registers: a control word, a duty word, a prescaler word and a start-up delay word. In PWM mode each output period is divided into 256 duty steps. Each step lasts a programmable number of input ticks, and the pin is high during the first `duty` steps. The input tick comes from one of two enables, a fast one and a slow one, chosen by a control bit. Two forced modes hold the pin low or high. Duty codes 0 and 255 also force the pin fully low or fully high.

A new duty value acts on the waveform at once. A new prescaler value is stored in a holding register only. Setting the update bit asks the hardware to move the held value into the active prescaler on the last tick of the current period, so a period is never stretched halfway through. The hardware clears the update bit once the move has been made. When the block leaves the off state, or on a soft reset, the pin is held low and the counters stay idle for a programmed number of ticks.

Top module: `led_pwm_gen`

## Requirements
- R1: After reset every register reads 0. The mode is off, the slow tick is selected and the pin is low.
- R2: The register map, by `wr_addr`/`rd_addr`, is as follows:
  - 0 is control: mode in [1:0], fast-tick select in bit 2, update in bit 6, soft reset in bit 7, which always reads 0.
  - 1 is duty: duty in [7:0] and an upper-limit field in [15:8].
  - 2 is prescaler: LD in [11:0] and a high-delay field in [23:12].
  - 3 is start-up delay in [7:0].
  - Bits not listed here read 0.
- R3: In mode 2 (PWM) with a duty from 1 to 254, the pin is high for exactly duty×(LD+1) ticks of every period.
- R4: Duty 0 keeps the pin low for the whole period. Duty 255 keeps it high for the whole period.
- R5: A write to the duty register changes the waveform at once. The first full period after the write already carries the new duty.
- R6: The output period is 256×(LD+1) ticks, where LD is the active prescaler.
- R7: A write to the prescaler register changes only the holding register, and a read returns the held value. The active period does not change until an update is requested.
- R8: Writing 1 to the update bit sets it, and writing 0 does not clear it. The held prescaler becomes active from the next period boundary. The bit then reads 0.
- R9: Modes 0 and 1 hold the pin low and clear the counters. Mode 3 holds the pin high.
- R10: With control bit 2 set, `tick_fast` advances the block. With bit 2 clear, `tick_slow` advances it.
- R11: When the mode goes from 0 or 1 to 2 or 3, the pin stays low for the start-up delay D, counted in ticks. The output is registered, so with the tick active on every cycle the pin first shows the new level D+1 clocks after the enabling write.
- R12: A control write with bit 7 set restarts the period at step 0 and reloads the start-up delay. The other control fields are written as usual.
- R13: The upper-limit field and the high-delay field are stored and read back. They have no effect on the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast | input | 1 | Fast tick enable |
| tick_slow | input | 1 | Slow tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| led_out | output | 1 | LED drive, active high |

## Verification
On every cycle the assertions check the following:
- The pin level stays low in the off modes, during the start-up delay and at duty 0, and stays high at duty 255.
- The prescale counter never passes the active prescaler.
- The active prescaler changes only while an update is pending, and it takes the held value.
- Off modes clear the counters.

The exact counts need the bench's scenarios. These are the high time and the period for each duty and prescaler, that a duty write acts at once, that the update waits for the period boundary, the start-up delay length, the soft-reset restart and the tick selection.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;

   typedef enum logic [1:0] {
      RA_CTRL  = 2'd0,
      RA_DUTY  = 2'd1,
      RA_PRESC = 2'd2,
      RA_START = 2'd3
   } reg_addr_e;

   typedef enum logic [1:0] {
      MD_OFF     = 2'd0,
      MD_OFF_ALT = 2'd1,
      MD_PWM     = 2'd2,
      MD_ON      = 2'd3
   } mode_e;

   localparam int CTL_FAST_BIT = 2;
   localparam int CTL_UPD_BIT  = 6;
   localparam int CTL_SRST_BIT = 7;

endpackage

// File: rtl/led_pwm_regs.sv
module led_pwm_regs
   import led_pwm_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DUTY_W = 8,
   parameter int PRE_W  = 12,
   parameter int HI_W   = 12,
   parameter int SDLY_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              xfer_done,
   output mode_e             mode,
   output logic              fast_sel,
   output logic              upd_pend,
   output logic              srst,
   output logic [DUTY_W-1:0] duty,
   output logic [PRE_W-1:0]  pre_hold,
   output logic [SDLY_W-1:0] start_dly
);

   localparam int LIM_W = 2 * DUTY_W;
   localparam int DLY_W = PRE_W + HI_W;

   if (LIM_W > DATA_W || DLY_W > DATA_W || SDLY_W > DATA_W || DATA_W < 8) begin : g_bad_widths
      $error("led_pwm_regs: field widths exceed DATA_W");
   end

   logic [DUTY_W-1:0] duty_max;
   logic [HI_W-1:0]   hi_hold;
   logic              unused_wdata;

   assign unused_wdata = ^wr_data;

   wire ctrl_wr = wr_en && (reg_addr_e'(wr_addr) == RA_CTRL);
   assign srst  = ctrl_wr && wr_data[CTL_SRST_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode      <= MD_OFF;
         fast_sel  <= 1'b0;
         upd_pend  <= 1'b0;
         duty      <= '0;
         duty_max  <= '0;
         pre_hold  <= '0;
         hi_hold   <= '0;
         start_dly <= '0;
      end else begin
         if (xfer_done)
            upd_pend <= 1'b0;
         if (wr_en) begin
            case (reg_addr_e'(wr_addr))
               RA_CTRL: begin
                  mode     <= mode_e'(wr_data[1:0]);
                  fast_sel <= wr_data[CTL_FAST_BIT];
                  if (wr_data[CTL_UPD_BIT])
                     upd_pend <= 1'b1;
               end
               RA_DUTY: begin
                  duty     <= wr_data[DUTY_W-1:0];
                  duty_max <= wr_data[LIM_W-1:DUTY_W];
               end
               RA_PRESC: begin
                  pre_hold <= wr_data[PRE_W-1:0];
                  hi_hold  <= wr_data[DLY_W-1:PRE_W];
               end
               default: start_dly <= wr_data[SDLY_W-1:0];
            endcase
         end
      end
   end

   always_comb begin
      rd_data = '0;
      case (reg_addr_e'(rd_addr))
         RA_CTRL: begin
            rd_data[1:0]         = mode;
            rd_data[CTL_FAST_BIT] = fast_sel;
            rd_data[CTL_UPD_BIT]  = upd_pend;
         end
         RA_DUTY: begin
            rd_data[DUTY_W-1:0]     = duty;
            rd_data[LIM_W-1:DUTY_W] = duty_max;
         end
         RA_PRESC: begin
            rd_data[PRE_W-1:0]     = pre_hold;
            rd_data[DLY_W-1:PRE_W] = hi_hold;
         end
         default: rd_data[SDLY_W-1:0] = start_dly;
      endcase
   end

   // R8: the update request is dropped only by a transfer, never by a write of 0
   p_upd_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(upd_pend) |-> $past(xfer_done));

endmodule

// File: rtl/led_pwm_engine.sv
module led_pwm_engine #(
   parameter int DUTY_W = 8,
   parameter int PRE_W  = 12,
   parameter int SDLY_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              tick,
   input  logic              srst,
   input  logic              upd_pend,
   input  logic [PRE_W-1:0]  pre_hold,
   input  logic [SDLY_W-1:0] start_dly,
   output logic [DUTY_W-1:0] step_cnt,
   output logic [PRE_W-1:0]  ld_act,
   output logic              running,
   output logic              dly_busy,
   output logic              xfer_done
);

   if (DUTY_W < 2 || PRE_W < 1 || SDLY_W < 1) begin : g_bad_widths
      $error("led_pwm_engine: widths too small");
   end

   logic [PRE_W-1:0]  pre_cnt;
   logic [SDLY_W-1:0] dly_cnt;

   assign running  = active && (dly_cnt == '0);
   assign dly_busy = active && (dly_cnt != '0);

   wire step_end   = running && tick && !srst && (pre_cnt == ld_act);
   wire period_end = step_end && (step_cnt == '1);
   assign xfer_done = period_end && upd_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_cnt  <= '0;
         step_cnt <= '0;
         dly_cnt  <= '0;
         ld_act   <= '0;
      end else if (!active || srst) begin
         pre_cnt  <= '0;
         step_cnt <= '0;
         dly_cnt  <= start_dly;
      end else if (tick) begin
         if (dly_cnt != '0) begin
            dly_cnt <= dly_cnt - 1'b1;
         end else if (pre_cnt == ld_act) begin
            pre_cnt  <= '0;
            step_cnt <= step_cnt + 1'b1;
            if (xfer_done)
               ld_act <= pre_hold;
         end else begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end

   // R6: the prescale counter never runs past the active prescaler
   p_pre_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= ld_act);

   // R7: the active prescaler moves only while an update is pending
   p_ld_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_act != $past(ld_act)) |-> ($past(upd_pend) && ld_act == $past(pre_hold)));

   // R9: off modes clear the counters
   p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (step_cnt == '0 && pre_cnt == '0));

endmodule

// File: rtl/led_pwm_outsel.sv
module led_pwm_outsel
   import led_pwm_pkg::*;
#(
   parameter int DUTY_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mode_e             mode,
   input  logic              running,
   input  logic [DUTY_W-1:0] step_cnt,
   input  logic [DUTY_W-1:0] duty,
   output logic              level,
   output logic              led
);

   always_comb begin
      case (mode)
         MD_PWM:  level = running && ((duty == '1) || (step_cnt < duty));
         MD_ON:   level = running;
         default: level = 1'b0;
      endcase
   end

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) led <= 1'b0;
         else        led <= level;
      end
   end else begin : g_comb_out
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign led = level;
   end

endmodule

// File: rtl/led_pwm_gen.sv
module led_pwm_gen
   import led_pwm_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int DUTY_W  = 8,
   parameter int PRE_W   = 12,
   parameter int HI_W    = 12,
   parameter int SDLY_W  = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_fast,
   input  logic              tick_slow,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              led_out
);

   mode_e             mode;
   logic              fast_sel, upd_pend, srst, xfer_done;
   logic              running, dly_busy, level, active, tick;
   logic [DUTY_W-1:0] duty, step_cnt;
   logic [PRE_W-1:0]  pre_hold, ld_act;
   logic [SDLY_W-1:0] start_dly;

   assign active = (mode == MD_PWM) || (mode == MD_ON);
   assign tick   = fast_sel ? tick_fast : tick_slow;

   led_pwm_regs #(
      .DATA_W(DATA_W), .DUTY_W(DUTY_W), .PRE_W(PRE_W), .HI_W(HI_W), .SDLY_W(SDLY_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .xfer_done(xfer_done), .mode(mode),
      .fast_sel(fast_sel), .upd_pend(upd_pend), .srst(srst), .duty(duty),
      .pre_hold(pre_hold), .start_dly(start_dly)
   );

   led_pwm_engine #(
      .DUTY_W(DUTY_W), .PRE_W(PRE_W), .SDLY_W(SDLY_W)
   ) u_engine (
      .clk(clk), .rst_n(rst_n), .active(active), .tick(tick), .srst(srst),
      .upd_pend(upd_pend), .pre_hold(pre_hold), .start_dly(start_dly),
      .step_cnt(step_cnt), .ld_act(ld_act), .running(running),
      .dly_busy(dly_busy), .xfer_done(xfer_done)
   );

   led_pwm_outsel #(
      .DUTY_W(DUTY_W), .REG_OUT(REG_OUT)
   ) u_out (
      .clk(clk), .rst_n(rst_n), .mode(mode), .running(running),
      .step_cnt(step_cnt), .duty(duty), .level(level), .led(led_out)
   );

   // R9: off modes keep the pin level low
   p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !level);

   // R11: no drive during the start-up delay
   p_startup_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dly_busy |-> !level);

   // R4: duty 255 is fully high while running in PWM mode
   p_full_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_PWM && running && duty == '1) |-> level);

   // R4: duty 0 is fully low
   p_zero_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_PWM && duty == '0) |-> !level);

endmodule

// File: tb/led_pwm_gen_test.sv
`timescale 1ns/1ps
module led_pwm_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_fast = 1'b1;
   logic        tick_slow;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        led_out;
   logic [1:0]  slow_div = '0;
   int          tests = 0;
   int          fails = 0;
   int          cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) slow_div <= slow_div + 2'd1;
   assign tick_slow = (slow_div == 2'd0);

   led_pwm_gen uut (
      .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .led_out(led_out)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      @(negedge clk);
      rd_addr = a;
      #1 v = rd_data;
   endtask

   task automatic count_high(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (led_out) c++;
      end
   endtask

   task automatic wait_rise(output int t);
      logic prev;
      int   n;
      prev = led_out;
      n = 0;
      t = -1;
      while (n < 20000) begin
         @(negedge clk);
         n++;
         if (!prev && led_out) begin
            t = cyc;
            break;
         end
         prev = led_out;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int c, t0, t1, t2, n;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check(led_out == 1'b0, "R1 pin low", led_out, 0);
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], v);
         check(v == 0, "R1 register reads 0", v, 0);
      end

      // R2 R13: map, masks, stored-only fields
      wr(2'd0, 32'h0000_00BC);
      rd(2'd0, v); check(v == 32'h4, "R2 R12 control readback", v, 32'h4);
      wr(2'd1, 32'hFFFF_A55A);
      rd(2'd1, v); check(v == 32'h0000_A55A, "R2 R13 duty readback", v, 32'hA55A);
      wr(2'd2, 32'hFF12_3456);
      rd(2'd2, v); check(v == 32'h0012_3456, "R2 R13 prescaler readback", v, 32'h123456);
      wr(2'd3, 32'hFFFF_FF00);
      rd(2'd3, v); check(v == 32'h0, "R2 start delay readback", v, 0);
      wr(2'd2, 32'h0);

      // R3 R4 R5: exhaustive duty sweep, LD = 0, fast tick
      wr(2'd0, 32'h6);
      for (int d = 0; d < 256; d++) begin
         wr(2'd1, d);
         count_high(256, c);
         if (d == 0 || d == 255)
            check(c == ((d == 255) ? 256 : 0), "R4 R5 forced duty", c, (d == 255) ? 256 : 0);
         else
            check(c == d, "R3 R5 duty high count", c, d);
      end

      // R6 R3: period and high time across prescalers
      for (int ld = 1; ld < 4; ld++) begin
         wr(2'd2, ld);
         wr(2'd0, 32'h46);
         n = 0;
         do begin rd(2'd0, v); n++; end while (v[6] && n < 5000);
         check(v[6] == 1'b0, "R8 update clears", v[6], 0);
         wr(2'd1, 100);
         count_high(256 * (ld + 1), c);
         check(c == 100 * (ld + 1), "R3 high count with prescaler", c, 100 * (ld + 1));
         wait_rise(t0); wait_rise(t1);
         check(t1 - t0 == 256 * (ld + 1), "R6 period", t1 - t0, 256 * (ld + 1));
      end

      // R7: holding-register write has no effect without update
      wr(2'd2, 32'h1);
      rd(2'd2, v); check(v == 1, "R7 held value read", v, 1);
      wait_rise(t0); wait_rise(t1);
      check(t1 - t0 == 1024, "R7 period unchanged", t1 - t0, 1024);

      // R8: update waits for boundary, write of 0 does not clear
      wait_rise(t0);
      wr(2'd0, 32'h46);
      rd(2'd0, v); check(v[6] == 1'b1, "R8 pending after set", v[6], 1);
      wr(2'd0, 32'h06);
      rd(2'd0, v); check(v[6] == 1'b1, "R8 write 0 keeps pending", v[6], 1);
      wait_rise(t1);
      check(t1 - t0 == 1024, "R8 old period finishes", t1 - t0, 1024);
      wait_rise(t2);
      check(t2 - t1 == 512, "R8 new period applied", t2 - t1, 512);
      rd(2'd0, v); check(v[6] == 1'b0, "R8 cleared by hardware", v[6], 0);

      // R13: upper-limit and high-delay fields do not touch the pin
      wr(2'd1, 32'h0000_FF64);
      wr(2'd2, 32'h00FF_F001);
      count_high(512, c);
      check(c == 200, "R13 duty unaffected", c, 200);
      wait_rise(t0); wait_rise(t1);
      check(t1 - t0 == 512, "R13 period unaffected", t1 - t0, 512);

      // R10: slow tick selected, one tick every 4 clocks
      wr(2'd0, 32'h2);
      wait_rise(t0); wait_rise(t1);
      check(t1 - t0 == 2048, "R10 slow tick period", t1 - t0, 2048);
      wr(2'd0, 32'h6);
      wait_rise(t0); wait_rise(t1);
      check(t1 - t0 == 512, "R10 fast tick period", t1 - t0, 512);

      // R9: modes
      wr(2'd0, 32'h4);
      count_high(600, c); check(c == 0, "R9 mode 0 low", c, 0);
      wr(2'd0, 32'h5);
      count_high(600, c); check(c == 0, "R9 mode 1 low", c, 0);
      wr(2'd0, 32'h7);
      count_high(300, c); check(c == 300, "R9 mode 3 high", c, 300);

      // R11: start-up delay
      wr(2'd0, 32'h4);
      wr(2'd3, 40);
      wr(2'd0, 32'h7);
      n = 0;
      while (!led_out && n < 1000) begin n++; @(negedge clk); end
      check(n == 41, "R11 delay 40", n, 41);
      wr(2'd0, 32'h4);
      wr(2'd3, 0);
      wr(2'd0, 32'h7);
      n = 0;
      while (!led_out && n < 1000) begin n++; @(negedge clk); end
      check(n == 1, "R11 delay 0", n, 1);

      // R12: soft reset restarts the period mid-high
      wr(2'd1, 128);
      wr(2'd0, 32'h6);
      wait_rise(t0);
      repeat (100) @(negedge clk);
      wr(2'd0, 32'h86);
      n = 0;
      @(negedge clk);
      while (led_out && n < 2000) begin n++; @(negedge clk); end
      check(n == 256, "R12 restart high run", n, 256);
      rd(2'd0, v); check(v == 32'h6, "R12 R2 reset bit reads 0", v, 6);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule